// File: doc/BRIEF.md
# Master-Mode Serial Audio Transmitter

This block sends stereo audio samples to an external processor over a three-wire serial link on which it is the clock master. It runs from a system clock at 256 times the sample rate. From that clock it derives the bit clock and the word select, and it shifts out a left/right pair of 24-bit samples on the serial data line. Each stereo frame is 64 bit clocks long: 32 bit slots for the left channel and 32 for the right. The slots a sample does not fill are sent as zero. Upstream logic has already applied any muting to the samples.

Two framings can be chosen at run time. In I2S framing the word starts one bit after the word-select edge. In LSB-justified framing the word ends on the last bit before the next word-select edge. Each framing can send 16, 20 or 24 bits. A load strobe stores a new sample pair, but the transmitter only switches to new samples, a new framing or a new length at a frame boundary. A frame that is being sent therefore never mixes old and new settings.

Top module: `i2s_master_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `bck`, `ws` and `sdata` are all low.
- R2: `bck` runs at one quarter of `clk`. It is high for two `clk` cycles and low for two, without a break.
- R3: A frame is 64 `bck` periods long. `ws` is low for 32 consecutive bit slots (left channel) and then high for 32 (right channel). `ws` changes only right after a falling edge of `bck`.
- R4: `sdata` changes only right after a falling edge of `bck`, so it is stable around every rising edge.
- R5: With `fmt_sel`=0 (I2S), the word's MSB is in bit slot 1 of its channel half, where slot 0 is the slot in which `ws` changed. The word follows MSB first, and all other slots of that half are zero.
- R6: With `fmt_sel`=1 (LSB-justified), the word's LSB is in slot 31 of its channel half, which is the last slot before the next `ws` change. The word occupies the W slots that end there, MSB first, and all earlier slots of that half are zero.
- R7: `wlen_sel` selects the word length W: 2'b00 gives 16, 2'b01 gives 20, and 2'b10 or 2'b11 give 24. The W most significant bits of each 24-bit sample are sent and the lower bits are dropped.
- R8: A pulse on `load` stores `left_in` and `right_in`. That pair is sent in every following frame until the next pulse. A pulse in the last `clk` cycle of a frame already applies to the frame that starts next.
- R9: If `load`, `fmt_sel` or `wlen_sel` change in the middle of a frame, the frame being sent is not affected. The change is first seen in the next frame.
- R10: The left half of each frame carries the left sample and the right half carries the right sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously |
| load | input | 1 | One-cycle strobe that stores a new sample pair |
| left_in | input | 24 | Left-channel sample, two's complement |
| right_in | input | 24 | Right-channel sample, two's complement |
| fmt_sel | input | 1 | Framing: 0 = I2S, 1 = LSB-justified |
| wlen_sel | input | 2 | Word length: 00 = 16, 01 = 20, 10/11 = 24 |
| bck | output | 1 | Bit clock, driven by this block |
| ws | output | 1 | Word select: 0 = left, 1 = right |
| sdata | output | 1 | Serial data |

## Verification
Stored samples and settings first appear in the frame that starts after the next frame boundary. A strobe given in the boundary cycle itself appears one frame earlier, in the frame that starts right after it. The bench never compares a fixed cycle count. It decodes the serial stream at each rising edge of `bck`, finds slot 0 from the falling edge of `ws`, and rebuilds complete frames. After each normal stimulus it skips the frame that may contain the boundary and compares the first frame that lies wholly after it. For the mid-frame and boundary-cycle cases it places the stimulus at a known slot and checks both frames on either side of the boundary.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } tx_fmt_e;

  localparam logic [1:0] WLEN_16 = 2'b00;
  localparam logic [1:0] WLEN_20 = 2'b01;

  // Word length in bits for a length code, limited to the sample width.
  function automatic int wlen_bits(input logic [1:0] code, input int max_w);
    int bits;
    case (code)
      WLEN_16: bits = 16;
      WLEN_20: bits = 20;
      default: bits = 24;
    endcase
    if (bits > max_w) bits = max_w;
    return bits;
  endfunction

endpackage

// File: rtl/i2s_tx_timing.sv
// Free-running frame counter. The low bits are the phase inside one bit
// slot and the high bits are the slot index, with the channel in the top bit.
module i2s_tx_timing #(
  parameter int CLK_PER_BIT  = 4,
  parameter int SLOTS_PER_CH = 32,
  localparam int DIV_W  = $clog2(CLK_PER_BIT),
  localparam int SLOT_W = $clog2(SLOTS_PER_CH),
  localparam int CNT_W  = DIV_W + SLOT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [SLOT_W:0] slot_nxt,
  output logic            bck_nxt,
  output logic            bit_edge,
  output logic            frame_wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [DIV_W-1:0] phase_nxt;

  always_comb begin
    cnt_d      = cnt_q + CNT_W'(1);
    phase_nxt  = cnt_d[DIV_W-1:0];
    slot_nxt   = cnt_d[CNT_W-1:DIV_W];
    bck_nxt    = phase_nxt[DIV_W-1];
    bit_edge   = (phase_nxt == '0);
    frame_wrap = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2s_tx_frame_regs.sv
// Pending sample pair (written on load) and the settings in force for the
// current frame (taken over at the frame boundary).
module i2s_tx_frame_regs #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic                frame_wrap,
  output logic [SAMPLE_W-1:0] eff_left,
  output logic [SAMPLE_W-1:0] eff_right,
  output logic                eff_fmt,
  output logic [1:0]          eff_wlen
);

  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
  logic [SAMPLE_W-1:0] pend_l_d, pend_r_d;
  logic [SAMPLE_W-1:0] act_l_q, act_r_q;
  logic                act_fmt_q;
  logic [1:0]          act_wlen_q;
  logic                pend_en, act_en;

  always_comb begin
    pend_en  = load;
    act_en   = frame_wrap;
    pend_l_d = load ? left_in  : pend_l_q;
    pend_r_d = load ? right_in : pend_r_q;
    // Values in force after the coming edge.
    if (act_en) begin
      eff_left  = pend_l_d;
      eff_right = pend_r_d;
      eff_fmt   = fmt_sel;
      eff_wlen  = wlen_sel;
    end else begin
      eff_left  = act_l_q;
      eff_right = act_r_q;
      eff_fmt   = act_fmt_q;
      eff_wlen  = act_wlen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (pend_en) begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_l_q    <= '0;
      act_r_q    <= '0;
      act_fmt_q  <= 1'b0;
      act_wlen_q <= 2'b00;
    end else if (act_en) begin
      act_l_q    <= eff_left;
      act_r_q    <= eff_right;
      act_fmt_q  <= eff_fmt;
      act_wlen_q <= eff_wlen;
    end
  end

endmodule

// File: rtl/i2s_tx_serializer.sv
// Chooses the bit for the next slot and registers the three line outputs.
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int SLOTS_PER_CH = 32,
  localparam int SLOT_W = $clog2(SLOTS_PER_CH),
  localparam int IDX_W  = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_W:0]     slot_nxt,
  input  logic                bck_nxt,
  input  logic                bit_edge,
  input  logic [SAMPLE_W-1:0] eff_left,
  input  logic [SAMPLE_W-1:0] eff_right,
  input  logic                eff_fmt,
  input  logic [1:0]          eff_wlen,
  output logic                bck,
  output logic                ws,
  output logic                sdata
);

  logic [SAMPLE_W-1:0] word;
  logic [IDX_W-1:0]    bit_sel;
  logic                ch_nxt;
  logic                sd_nxt;
  int                  pos_i, wbits_i, idx_i;

  always_comb begin
    ch_nxt  = slot_nxt[SLOT_W];
    pos_i   = int'(slot_nxt[SLOT_W-1:0]);
    wbits_i = wlen_bits(eff_wlen, SAMPLE_W);
    word    = ch_nxt ? eff_right : eff_left;
    if (eff_fmt == FMT_LSBJ) idx_i = pos_i - (SLOTS_PER_CH - wbits_i);
    else                     idx_i = pos_i - 1;
    bit_sel = '0;
    sd_nxt  = 1'b0;
    if (idx_i >= 0 && idx_i < wbits_i) begin
      bit_sel = IDX_W'(SAMPLE_W - 1 - idx_i);
      sd_nxt  = word[bit_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck <= 1'b0;
    else        bck <= bck_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws    <= 1'b0;
      sdata <= 1'b0;
    end else if (bit_edge) begin
      ws    <= ch_nxt;
      sdata <= sd_nxt;
    end
  end

endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx #(
  parameter int SAMPLE_W     = 24,
  parameter int CLK_PER_BIT  = 4,
  parameter int SLOTS_PER_CH = 32,
  localparam int SLOT_W = $clog2(SLOTS_PER_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                fmt_sel,
  input  logic [1:0]          wlen_sel,
  output logic                bck,
  output logic                ws,
  output logic                sdata
);

  logic [SLOT_W:0]     slot_nxt;
  logic                bck_nxt, bit_edge, frame_wrap;
  logic [SAMPLE_W-1:0] eff_left, eff_right;
  logic                eff_fmt;
  logic [1:0]          eff_wlen;

  i2s_tx_timing #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .SLOTS_PER_CH(SLOTS_PER_CH)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_nxt  (slot_nxt),
    .bck_nxt   (bck_nxt),
    .bit_edge  (bit_edge),
    .frame_wrap(frame_wrap)
  );

  i2s_tx_frame_regs #(
    .SAMPLE_W(SAMPLE_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .left_in   (left_in),
    .right_in  (right_in),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .frame_wrap(frame_wrap),
    .eff_left  (eff_left),
    .eff_right (eff_right),
    .eff_fmt   (eff_fmt),
    .eff_wlen  (eff_wlen)
  );

  i2s_tx_serializer #(
    .SAMPLE_W    (SAMPLE_W),
    .SLOTS_PER_CH(SLOTS_PER_CH)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_nxt (slot_nxt),
    .bck_nxt  (bck_nxt),
    .bit_edge (bit_edge),
    .eff_left (eff_left),
    .eff_right(eff_right),
    .eff_fmt  (eff_fmt),
    .eff_wlen (eff_wlen),
    .bck      (bck),
    .ws       (ws),
    .sdata    (sdata)
  );

endmodule

// File: rtl/i2s_master_tx_chk.sv
module i2s_master_tx_chk #(
  parameter int SLOTS_PER_CH = 32,
  localparam int FC_W = $clog2(SLOTS_PER_CH) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic bck,
  input logic ws,
  input logic sdata
);

  logic            bck_d, ws_d, sd_d;
  logic [FC_W-1:0] fall_cnt;
  logic            bck_fall;

  assign bck_fall = bck_d && !bck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d    <= 1'b0;
      ws_d     <= 1'b0;
      sd_d     <= 1'b0;
      fall_cnt <= '0;
    end else begin
      bck_d <= bck;
      ws_d  <= ws;
      sd_d  <= sdata;
      if (bck_fall) fall_cnt <= (ws != ws_d) ? '0 : fall_cnt + FC_W'(1);
    end
  end

  AST_SD_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != sd_d) |-> bck_fall);  // R4

  AST_WS_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != ws_d) |-> bck_fall);  // R3

  AST_WS_HALF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != ws_d) |-> (fall_cnt == FC_W'(SLOTS_PER_CH - 1)));  // R3

  AST_SLOT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != ws_d) |-> !sdata);  // R5

endmodule

bind i2s_master_tx i2s_master_tx_chk #(
  .SLOTS_PER_CH(SLOTS_PER_CH)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .bck  (bck),
  .ws   (ws),
  .sdata(sdata)
);

// File: tb/test_i2s_master_tx.sv
module test_i2s_master_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [23:0] left_in = '0, right_in = '0;
  logic        fmt_sel = 1'b0;
  logic [1:0]  wlen_sel = 2'b00;
  logic        bck, ws, sdata;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_master_tx i_i2s_master_tx (
    .clk(clk), .rst_n(rst_n), .load(load), .left_in(left_in), .right_in(right_in),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .bck(bck), .ws(ws), .sdata(sdata)
  );

  // Stream decoder: samples at the falling clk edge, rebuilds frames.
  logic        p_bck = 1'b0, p_ws = 1'b0, p_sd = 1'b0, rise_ws = 1'b0;
  logic [63:0] cur_sd = '0, cur_ws = '0, got_sd = '0, got_ws = '0;
  int slot = -1, since_rise = 0, rises = 0, frames_seen = 0;
  int period_err = 0, edge_err = 0, len_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if ((sdata !== p_sd || ws !== p_ws) && !(p_bck && !bck)) edge_err++;
      if (!p_bck && bck) begin
        if (rises > 0 && since_rise != 4) period_err++;
        rises++;
        since_rise = 0;
        if (rise_ws && !ws) begin
          if (slot >= 0 && slot != 63) len_err++;
          slot = 0;
        end else if (slot >= 0) slot++;
        if (slot >= 0 && slot < 64) begin
          cur_sd[slot] = sdata;
          cur_ws[slot] = ws;
          if (slot == 63) begin
            got_sd = cur_sd;
            got_ws = cur_ws;
            frames_seen++;
          end
        end
        rise_ws = ws;
      end
      p_bck = bck; p_ws = ws; p_sd = sdata;
    end
  end

  function automatic logic [63:0] exp_frame(logic f, logic [1:0] wl, logic [23:0] l, logic [23:0] r);
    logic [63:0] e = '0;
    int w = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : 24;
    for (int s = 0; s < 64; s++) begin
      logic [23:0] smp = (s >= 32) ? r : l;
      int p = s % 32;
      int k = f ? p - (32 - w) : p - 1;
      if (k >= 0 && k < w) e[s] = smp[23 - k];
    end
    return e;
  endfunction

  task automatic check_frame(logic f, logic [1:0] wl, logic [23:0] l, logic [23:0] r, string tag);
    logic [63:0] e = exp_frame(f, wl, l, r);
    checks++;
    if (got_sd !== e) begin
      failures++;
      $display("FAIL %s fmt=%0d wlen=%0d data got=%h exp=%h", tag, f, wl, got_sd, e);
    end
    checks++;
    if (got_ws !== {32'hFFFF_FFFF, 32'h0}) begin
      failures++;
      $display("FAIL R3 ws pattern got=%h exp=%h", got_ws, {32'hFFFF_FFFF, 32'h0});
    end
  endtask

  task automatic apply(logic f, logic [1:0] wl, logic [23:0] l, logic [23:0] r);
    int n;
    @(negedge clk);
    fmt_sel = f; wlen_sel = wl; left_in = l; right_in = r; load = 1'b1;
    @(negedge clk);
    load = 1'b0; left_in = ~l; right_in = ~r;
    n = frames_seen;
    wait (frames_seen >= n + 2);
  endtask

  function automatic string fmt_tag(logic f);
    return f ? "R6/R7/R10" : "R5/R7/R10";
  endfunction

  initial begin
    logic [23:0] pl [3];
    logic [23:0] pr [3];
    int n;
    pl[0] = 24'h800001; pr[0] = 24'h7FFFFE;
    pl[1] = 24'hC3A5F1; pr[1] = 24'h1E2D4B;
    pl[2] = 24'hFFFFFF; pr[2] = 24'h000000;

    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if ({bck, ws, sdata} !== 3'b000) begin
      failures++; $display("FAIL R1 in reset got=%b exp=000", {bck, ws, sdata});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 first cycle after release
    if ({bck, ws, sdata} !== 3'b000) begin
      failures++; $display("FAIL R1 after release got=%b exp=000", {bck, ws, sdata});
    end

    // Sweep of framings, lengths and patterns.
    for (int f = 0; f < 2; f++) begin
      for (int wl = 0; wl < 4; wl++) begin
        for (int p = 0; p < 3; p++) begin
          apply(f[0], wl[1:0], pl[p], pr[p]);
          check_frame(f[0], wl[1:0], pl[p], pr[p], fmt_tag(f[0]));
        end
        // R8: the stored pair repeats with no further load.
        n = frames_seen;
        wait (frames_seen >= n + 1);
        check_frame(f[0], wl[1:0], pl[2], pr[2], "R8 repeat");
      end
    end

    // R9: mid-frame changes reach only the next frame.
    apply(1'b0, 2'b10, 24'h5A5A5A, 24'h3C3C3C);
    n = frames_seen;
    wait (frames_seen >= n + 1);
    wait (slot == 10);
    @(negedge clk);
    fmt_sel = 1'b1; wlen_sel = 2'b00; left_in = 24'h123456; right_in = 24'hFEDCBA; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    wait (frames_seen >= n + 2);
    check_frame(1'b0, 2'b10, 24'h5A5A5A, 24'h3C3C3C, "R9 current frame");
    wait (frames_seen >= n + 3);
    check_frame(1'b1, 2'b00, 24'h123456, 24'hFEDCBA, "R9 next frame");

    // R8: load in the last cycle of a frame applies to the next frame.
    n = frames_seen;
    wait (frames_seen >= n + 1);
    @(negedge clk);
    fmt_sel = 1'b0; wlen_sel = 2'b01; left_in = 24'hA0F00F; right_in = 24'h0FF0A5; load = 1'b1;
    @(negedge clk);
    load = 1'b0; left_in = '0; right_in = '0;
    wait (frames_seen >= n + 2);
    check_frame(1'b0, 2'b01, 24'hA0F00F, 24'h0FF0A5, "R8 boundary load");

    checks++;
    if (period_err != 0) begin
      failures++; $display("FAIL R2 bck period errors got=%0d exp=0", period_err);
    end
    checks++;
    if (edge_err != 0) begin
      failures++; $display("FAIL R4 changes off bck fall got=%0d exp=0", edge_err);
    end
    checks++;
    if (len_err != 0) begin
      failures++; $display("FAIL R3 frame length errors got=%0d exp=0", len_err);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule